// File: doc/BRIEF.md
# Reservation-Checked Shared Word Memory

This block places a small word memory behind several requester ports and gives software the two primitives it needs to build atomic read-modify-write sequences without a locked bus: a reserving load and a conditional store. Each port may issue a plain load, a plain store, a reserving load (which also records a reservation on that address), or a conditional store. The conditional store only takes effect if the port's reservation is still unbroken. A round-robin arbiter accepts one request per cycle, so each access is indivisible with respect to every other access.

Every port holds one reservation, made of a valid bit and an address. Any completed write to a reserved address breaks the reservation, whichever port made the write. A conditional store never waits. It answers 1 when it has written and 0 when it has been refused. Software retries the reserving-load and conditional-store pair until it gets a 1. That loop builds exchange, fetch-and-increment and lock acquisition on top of the block.

Top module: `llsc_monitor`

## Requirements
- R1: Reset (synchronous, active low) clears every reservation and sets every memory word to 0. A conditional store issued straight after reset returns 0 and does not write.
- R2: A reserving load (op code 2) returns the addressed word and records that address as the requesting port's reservation.
- R3: A plain load (op code 0) returns the addressed word. A plain store (op code 1) writes its data and returns 0.
- R4: A conditional store (op code 3) whose port holds a valid reservation on the same address writes its data and returns 1.
- R5: A refused conditional store leaves memory unchanged and returns 0.
- R6: A completed write by any port, the reserving port included, breaks every reservation on that address. A write to a different address leaves the reservation intact.
- R7: A conditional store to an address other than the reserved one is refused.
- R8: A conditional store clears its own port's reservation whatever its outcome, so a second conditional store without a new reserving load is refused.
- R9: Each cycle at most one port is accepted (req_ready one-hot or zero), only a port with req_valid high is accepted, and a port that keeps requesting is served within N accepted requests because the grant rotates round-robin.
- R10: Each accepted request produces exactly one response, on the cycle after acceptance: rsp_valid is high only for that port, and rsp_data carries the result.
- R11: A failed reserving-load and conditional-store pair can be retried without limit. A retry with no intervening write succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | Per-port request valid |
| req_ready | output | N | Per-port accept, high in the cycle the request is taken |
| req_op | input | 2*N | Port i op code in bits [2i+1:2i]: 0 load, 1 store, 2 reserving load, 3 conditional store |
| req_addr | input | AW*N | Port i word address in bits [AW*i+AW-1:AW*i] |
| req_wdata | input | DW*N | Port i store data in bits [DW*i+DW-1:DW*i] |
| rsp_valid | output | N | Per-port response strobe, one cycle after acceptance |
| rsp_data | output | DW | Response value for the port whose rsp_valid is high |

## Verification
A stale reservation shows up the first time its port issues a conditional store. The store returns 1 where 0 was due, and the next load of that address returns the conditional data in place of the intervening store's data. A lost reservation has the opposite effect, with the same one-request delay. The sweep runs every pair of reserving port and writing port, with the write both on and off the reserved address, so any wrong clearing rule shows up within one reserve, write, conditional-store and load sequence. An arbiter pointer fault shows up within N cycles as a repeated or missing grant while all ports request.

// File: rtl/llsc_pkg.sv
// Shared types for the reservation-checked memory.
package llsc_pkg;
    // Request op codes; values are part of the port contract.
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } mem_op_e;
endpackage

// File: rtl/llsc_rr_arb.sv
// Round-robin arbiter. Grants the first requester at or after the
// rotating pointer; the pointer moves past the winner after each grant.
// Assumes requests are level signals held until granted.
module llsc_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any_gnt
);
    logic [IW-1:0] ptr;
    int            cand;

    // Search from the pointer for the first active request.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any_gnt = 1'b0;
        cand    = 0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(ptr) + k) % N;
            if (!any_gnt && req[cand]) begin
                any_gnt   = 1'b1;
                gnt[cand] = 1'b1;
                gnt_idx   = IW'(cand);
            end
        end
    end

    // Move priority to the port after the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (any_gnt)
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R9
    AST_GRANT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R9
endmodule

// File: rtl/llsc_word_mem.sv
// Word memory with combinational read and one write port.
// Assumes at most one access per cycle (enforced by the arbiter).
module llsc_word_mem #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    // Clear on reset, otherwise write the selected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    // Read the selected word.
    assign rdata = words[addr];
endmodule

// File: rtl/llsc_link_tab.sv
// Per-port reservation table. A reserving load sets the port's entry;
// a conditional store clears its own entry; any completed write clears
// every entry holding the written address. Assumes one access per cycle.
module llsc_link_tab
    import llsc_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [IW-1:0] idx,
    input  mem_op_e       op,
    input  logic [AW-1:0] addr,
    output logic          cond_ok,
    output logic          wr_fire
);
    logic [N-1:0]  link_vld;
    logic [AW-1:0] link_addr [N];

    // Conditional store passes only on a live reservation for this address.
    assign cond_ok = link_vld[idx] && (link_addr[idx] == addr);
    // A write completes on a store or a passing conditional store.
    assign wr_fire = fire && ((op == OP_STORE) || ((op == OP_COND) && cond_ok));

    for (genvar p = 0; p < N; p++) begin : g_entry
        // Update one port's reservation entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                link_vld[p]  <= 1'b0;
                link_addr[p] <= '0;
            end else if (fire && idx == IW'(p) && op == OP_LINK) begin
                link_vld[p]  <= 1'b1;
                link_addr[p] <= addr;
            end else if (fire && idx == IW'(p) && op == OP_COND) begin
                link_vld[p]  <= 1'b0;
            end else if (wr_fire && link_addr[p] == addr) begin
                link_vld[p]  <= 1'b0;
            end
        end
    end

    // Checker state: last address seen and entries still holding it.
    logic [AW-1:0] prev_addr;
    logic [N-1:0]  stale;
    always_ff @(posedge clk) begin
        if (!rst_n) prev_addr <= '0;
        else        prev_addr <= addr;
    end
    for (genvar p = 0; p < N; p++) begin : g_stale
        assign stale[p] = link_vld[p] && (link_addr[p] == prev_addr);
    end

    AST_LINK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_LINK) |=> link_vld[$past(idx)]); // R2
    AST_COND_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_COND) |=> !link_vld[$past(idx)]); // R8
    AST_WRITE_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (stale == '0)); // R6
endmodule

// File: rtl/llsc_monitor.sv
// Multi-port shared word memory with reserving load and conditional
// store. One request is accepted per cycle by round-robin; the response
// is registered and appears on the next cycle for the accepted port.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    output logic [N-1:0]    req_ready,
    input  logic [2*N-1:0]  req_op,
    input  logic [AW*N-1:0] req_addr,
    input  logic [DW*N-1:0] req_wdata,
    output logic [N-1:0]    rsp_valid,
    output logic [DW-1:0]   rsp_data
);
    mem_op_e       port_op    [N];
    logic [AW-1:0] port_addr  [N];
    logic [DW-1:0] port_wdata [N];

    for (genvar i = 0; i < N; i++) begin : g_unpack
        assign port_op[i]    = mem_op_e'(req_op[2*i +: 2]);
        assign port_addr[i]  = req_addr[AW*i +: AW];
        assign port_wdata[i] = req_wdata[DW*i +: DW];
    end

    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;
    logic          fire;

    llsc_rr_arb #(.N(N)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any_gnt (fire)
    );
    assign req_ready = gnt;

    mem_op_e       sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;

    // Route the granted port's request fields.
    always_comb begin
        sel_op    = OP_LOAD;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_idx == IW'(i)) begin
                sel_op    = port_op[i];
                sel_addr  = port_addr[i];
                sel_wdata = port_wdata[i];
            end
        end
    end

    logic          cond_ok;
    logic          wr_fire;
    logic [DW-1:0] rdata;

    llsc_link_tab #(.N(N), .AW(AW)) i_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .idx     (gnt_idx),
        .op      (sel_op),
        .addr    (sel_addr),
        .cond_ok (cond_ok),
        .wr_fire (wr_fire)
    );

    llsc_word_mem #(.AW(AW), .DW(DW)) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (rdata)
    );

    // Register the response for the accepted port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= gnt;
            if (!fire)
                rsp_data <= '0;
            else begin
                unique case (sel_op)
                    OP_LOAD, OP_LINK: rsp_data <= rdata;
                    OP_STORE:         rsp_data <= '0;
                    OP_COND:          rsp_data <= DW'(cond_ok);
                endcase
            end
        end
    end

    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R10
endmodule

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_ready;
    logic [2*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    rsp_valid;
    logic [DW-1:0]   rsp_data;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] shadow [1 << AW];

    always #4 clk = ~clk;

    llsc_monitor #(.N(N), .AW(AW), .DW(DW)) i_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One request from port p; returns response data. Checks R10 framing.
    task automatic run_op(input int p, input logic [1:0] o, input int a, input int d,
                          output logic [DW-1:0] r);
        @(negedge clk);
        req_valid          = N'(1) << p;
        req_op[2*p +: 2]   = o;
        req_addr[AW*p +: AW] = AW'(a);
        req_wdata[DW*p +: DW] = DW'(d);
        #1;
        chk(req_ready == (N'(1) << p), "R9 lone requester accepted", req_ready, N'(1) << p);
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        chk(rsp_valid == (N'(1) << p), "R10 response strobe", rsp_valid, N'(1) << p);
        r = rsp_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state and R9 no accept without valid
        chk(rsp_valid == '0, "R1 rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == '0, "R9 no ready without valid", req_ready, 0);
        for (int p = 0; p < N; p++) begin
            run_op(p, 2'd3, p, 16'hdead, r);
            chk(r == 0, "R1 cond store after reset refused", r, 0);
        end
        for (int a = 0; a < (1 << AW); a++) begin
            run_op(0, 2'd0, a, 0, r);
            chk(r == 0, "R1 memory cleared", r, 0);
        end

        // R3 store then load over all addresses, rotating ports
        for (int a = 0; a < (1 << AW); a++) begin
            run_op(a % N, 2'd1, a, 16'h5a00 + a * 3, r);
            shadow[a] = DW'(16'h5a00 + a * 3);
            chk(r == 0, "R3 store response", r, 0);
        end
        for (int a = 0; a < (1 << AW); a++) begin
            run_op((a + 1) % N, 2'd0, a, 0, r);
            chk(r == shadow[a], "R3 load data", r, shadow[a]);
        end

        // R2 R4 R5 R6 sweep: reserver p, writer q, write on or off the address
        for (int p = 0; p < N; p++) begin
            for (int q = 0; q < N; q++) begin
                for (int hit = 0; hit < 2; hit++) begin
                    int a, b, w, s;
                    bit exp_ok;
                    a = (p * N + q) % (1 << AW);
                    b = hit ? a : (a ^ 1);
                    w = 16'h1000 + p * 64 + q * 8 + hit;
                    s = 16'h2000 + p * 64 + q * 8 + hit;
                    run_op(p, 2'd2, a, 0, r);
                    chk(r == shadow[a], "R2 reserving load data", r, shadow[a]);
                    run_op(q, 2'd1, b, w, r);
                    shadow[b] = DW'(w);
                    exp_ok = (hit == 0);
                    run_op(p, 2'd3, a, s, r);
                    chk(r == DW'(exp_ok), exp_ok ? "R4 cond store passes" : "R6 write breaks reservation",
                        r, exp_ok);
                    if (exp_ok) shadow[a] = DW'(s);
                    run_op((p + 1) % N, 2'd0, a, 0, r);
                    chk(r == shadow[a], "R5 memory after cond store", r, shadow[a]);
                end
            end
        end

        // R7 cond store to a different address than reserved
        run_op(2, 2'd2, 6, 0, r);
        run_op(2, 2'd3, 7, 16'hbeef, r);
        chk(r == 0, "R7 other-address cond refused", r, 0);
        run_op(1, 2'd0, 7, 0, r);
        chk(r == shadow[7], "R7 memory untouched", r, shadow[7]);

        // R8 second cond store without new reservation
        run_op(3, 2'd2, 9, 0, r);
        run_op(3, 2'd3, 9, 16'h0111, r);
        chk(r == 1, "R8 first cond passes", r, 1);
        shadow[9] = 16'h0111;
        run_op(3, 2'd3, 9, 16'h0222, r);
        chk(r == 0, "R8 second cond refused", r, 0);
        run_op(0, 2'd0, 9, 0, r);
        chk(r == shadow[9], "R8 memory keeps first", r, shadow[9]);

        // R11 fetch-and-increment with one forced retry
        begin
            logic [DW-1:0] v;
            run_op(0, 2'd2, 12, 0, v);
            run_op(1, 2'd1, 12, 16'h0040, r);
            shadow[12] = 16'h0040;
            run_op(0, 2'd3, 12, v + 1, r);
            chk(r == 0, "R11 first attempt refused", r, 0);
            run_op(0, 2'd2, 12, 0, v);
            chk(v == 16'h0040, "R11 retry reads new value", v, 16'h0040);
            run_op(0, 2'd3, 12, v + 1, r);
            chk(r == 1, "R11 retry passes", r, 1);
            run_op(2, 2'd0, 12, 0, r);
            chk(r == 16'h0041, "R11 incremented", r, 16'h0041);
        end

        // R9 all four request: each served once, one per cycle
        begin
            logic [N-1:0] pending, g, seen;
            pending = '1; seen = '0;
            @(negedge clk);
            for (int p = 0; p < N; p++) begin
                req_op[2*p +: 2] = 2'd0;
                req_addr[AW*p +: AW] = AW'(p);
            end
            req_valid = pending;
            for (int it = 0; it < N; it++) begin
                #1;
                g = req_ready;
                chk($onehot(g) && ((g & ~pending) == 0), "R9 one grant to a requester", g, pending);
                seen |= g;
                @(posedge clk);
                @(negedge clk);
                chk(rsp_valid == g, "R10 response to granted port", rsp_valid, g);
                pending &= ~g;
                req_valid = pending;
            end
            chk(seen == '1, "R9 every port served", seen, 4'hf);
        end

        // R9 two steady requesters alternate
        begin
            logic [N-1:0] g, prev;
            prev = '0;
            @(negedge clk);
            req_valid = 4'b1010;
            for (int it = 0; it < 6; it++) begin
                #1;
                g = req_ready;
                chk((g == 4'b0010 || g == 4'b1000) && g != prev, "R9 alternation", g, ~prev & 4'b1010);
                prev = g;
                @(negedge clk);
            end
            req_valid = '0;
            @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule